// File: doc/BRIEF.md
# Execute Latency Sequencer

This block sets the timing of the execute stage in a short in-order pipeline. Each cycle it receives a decoded instruction class, a valid strobe, a flag that marks a branch as conditional, and the result of that condition test. When the stage is free and a valid instruction arrives, the block looks up how many cycles that class needs and loads this number into a down-counter. While the counter is non-zero, the `exec_done_o` line to the fetch and decode stages stays low, and those stages hold their contents.

Branches take one of three costs. A conditional branch that falls through is cheap. A taken branch and an unconditional jump both cost more. The cost for every class comes from a parameter table, so an integration can retune it. A class code outside the defined set, or a table entry of zero, cannot be timed. The block refuses such an instruction and sets a sticky error flag.

Top module: `exec_lat_seq`

## Requirements
- R1: Reset state. While `rst_ni` is low, and after it is released, `exec_done_o` is 1 and `err_o` is 0.
- R2: Acceptance.
  - An instruction is accepted at a rising edge where `valid_i` is 1 and `exec_done_o` is 1.
  - `exec_done_o` is 0 in the cycle that follows that edge.
- R3: Non-branch latencies, given as class code → cycles.
  - The cycle count is the number of cycles `exec_done_o` stays low.
  - 0 simple ALU or float add/sub → 1.
  - 1 integer mul/div → 4.
  - 2 float mul/div → 4.
  - 3 memory/push/pop → 2.
  - 4 immediate load → 1.
  - 6 call/return → 4.
  - 7 sine/cosine → 4.
  - 8 register move → 1.
- R4: Branch class (code 5) latencies.
  - With `cond_i`=1 and `cond_met_i`=0, the latency is 1.
  - With `cond_i`=1 and `cond_met_i`=1, the latency is 3.
  - With `cond_i`=0, the latency is 3 whatever the value of `cond_met_i`.
- R5: NOP (code 9) and HALT (code 10) each hold `exec_done_o` low for exactly 1 cycle.
- R6: While `exec_done_o` is 0, `valid_i` is ignored. It neither restarts nor lengthens the current count.
- R7: With `exec_done_o` at 1 and `valid_i` at 0, `exec_done_o` stays 1.
- R8: Untimed instructions.
  - This covers a valid accepted instruction with class code 11 to 15, or one whose table entry is zero.
  - Such an instruction sets `err_o` in the next cycle.
  - It does not load the counter, so `exec_done_o` stays 1.
- R9: `err_o` stays 1 until reset, including across later legal instructions.
- R10: With `valid_i` held at 1, the next instruction is accepted at the first edge after `exec_done_o` returns to 1. Exactly one high cycle therefore separates consecutive busy windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Decoded instruction present |
| class_i | input | 4 | Instruction class code |
| cond_i | input | 1 | Branch is conditional |
| cond_met_i | input | 1 | Branch condition evaluated true |
| exec_done_o | output | 1 | Stage free, to fetch and decode |
| err_o | output | 1 | Sticky internal error |

## Verification
Take an instruction presented before edge k. Its busy window is visible at the first sample after edge k, and it lasts the expected latency L. `exec_done_o` is high again at the sample after edge k+L. The error flag for an untimed class is visible at the sample right after its acceptance edge. The driver pushes each expected latency into a scoreboard queue at the moment it presents an instruction. A monitor counts low samples taken on the falling edge and compares the count against the queue head at the first high sample. Any busy window that appears with the queue empty is reported as a spurious acceptance.

// File: rtl/exec_lat_pkg.sv
package exec_lat_pkg;
  localparam int CNT_W     = 8;
  localparam int CLS_W     = 4;
  localparam int NUM_SLOTS = 11;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU     = 4'd0,
    CLS_IMULDIV = 4'd1,
    CLS_FMULDIV = 4'd2,
    CLS_MEM     = 4'd3,
    CLS_IMM     = 4'd4,
    CLS_BRANCH  = 4'd5,
    CLS_CALLRET = 4'd6,
    CLS_TRIG    = 4'd7,
    CLS_MOVE    = 4'd8,
    CLS_NOP     = 4'd9,
    CLS_HALT    = 4'd10
  } cls_e;

  localparam int SLOT_ALU     = 0;
  localparam int SLOT_IMULDIV = 1;
  localparam int SLOT_FMULDIV = 2;
  localparam int SLOT_MEM     = 3;
  localparam int SLOT_IMM     = 4;
  localparam int SLOT_BR_MISS = 5;
  localparam int SLOT_BR_TAKE = 6;
  localparam int SLOT_BR_JUMP = 7;
  localparam int SLOT_CALLRET = 8;
  localparam int SLOT_TRIG    = 9;
  localparam int SLOT_MOVE    = 10;

  typedef logic [CNT_W-1:0] lat_t;
  typedef logic [NUM_SLOTS-1:0][CNT_W-1:0] lat_tab_t;

  function automatic lat_tab_t default_tab();
    lat_tab_t t;
    t = '0;
    t[SLOT_ALU]     = lat_t'(1);
    t[SLOT_IMULDIV] = lat_t'(4);
    t[SLOT_FMULDIV] = lat_t'(4);
    t[SLOT_MEM]     = lat_t'(2);
    t[SLOT_IMM]     = lat_t'(1);
    t[SLOT_BR_MISS] = lat_t'(1);
    t[SLOT_BR_TAKE] = lat_t'(3);
    t[SLOT_BR_JUMP] = lat_t'(3);
    t[SLOT_CALLRET] = lat_t'(4);
    t[SLOT_TRIG]    = lat_t'(4);
    t[SLOT_MOVE]    = lat_t'(1);
    return t;
  endfunction
endpackage

// File: rtl/exec_lat_lookup.sv
module exec_lat_lookup
  import exec_lat_pkg::*;
#(
  parameter lat_tab_t LAT_TAB = default_tab()
) (
  input  logic [CLS_W-1:0] class_i,
  input  logic             cond_i,
  input  logic             cond_met_i,
  output lat_t             lat_o,
  output logic             bad_o
);
  always_comb begin
    lat_o = '0;
    bad_o = 1'b0;
    case (class_i)
      CLS_ALU:     lat_o = LAT_TAB[SLOT_ALU];
      CLS_IMULDIV: lat_o = LAT_TAB[SLOT_IMULDIV];
      CLS_FMULDIV: lat_o = LAT_TAB[SLOT_FMULDIV];
      CLS_MEM:     lat_o = LAT_TAB[SLOT_MEM];
      CLS_IMM:     lat_o = LAT_TAB[SLOT_IMM];
      CLS_BRANCH: begin
        if (!cond_i)        lat_o = LAT_TAB[SLOT_BR_JUMP];
        else if (cond_met_i) lat_o = LAT_TAB[SLOT_BR_TAKE];
        else                lat_o = LAT_TAB[SLOT_BR_MISS];
      end
      CLS_CALLRET: lat_o = LAT_TAB[SLOT_CALLRET];
      CLS_TRIG:    lat_o = LAT_TAB[SLOT_TRIG];
      CLS_MOVE:    lat_o = LAT_TAB[SLOT_MOVE];
      CLS_NOP,
      CLS_HALT:    lat_o = lat_t'(1);
      default:     bad_o = 1'b1;
    endcase
    // zero latency cannot be counted down
    if (lat_o == '0) bad_o = 1'b1;
  end
endmodule

// File: rtl/exec_lat_counter.sv
module exec_lat_counter
  import exec_lat_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  lat_t load_val_i,
  output lat_t cnt_o,
  output logic zero_o
);
  lat_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - lat_t'(1);
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/exec_lat_seq.sv
module exec_lat_seq
  import exec_lat_pkg::*;
#(
  parameter lat_tab_t LAT_TAB = default_tab()
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [CLS_W-1:0] class_i,
  input  logic             cond_i,
  input  logic             cond_met_i,
  output logic             exec_done_o,
  output logic             err_o
);
  lat_t lat;
  logic bad;
  logic idle;
  lat_t cnt_q;
  logic accept;
  logic fault;
  logic err_q;

  exec_lat_lookup #(.LAT_TAB(LAT_TAB)) u_lookup (
    .class_i    (class_i),
    .cond_i     (cond_i),
    .cond_met_i (cond_met_i),
    .lat_o      (lat),
    .bad_o      (bad)
  );

  assign accept = valid_i & idle;
  assign fault  = accept & bad;

  exec_lat_counter u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept & ~bad),
    .load_val_i (lat),
    .cnt_o      (cnt_q),
    .zero_o     (idle)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= 1'b0;
    else if (fault) err_q <= 1'b1;
  end

  assign exec_done_o = idle;
  assign err_o       = err_q;
endmodule

// File: rtl/exec_lat_chk.sv
module exec_lat_chk
  import exec_lat_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [CLS_W-1:0] class_i,
  input logic             exec_done_o,
  input logic             err_o,
  input lat_t             cnt
);
  // R7
  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_done_o && !valid_i |=> exec_done_o);
  // R3
  p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt != '0 |=> cnt == $past(cnt) - lat_t'(1));
  // R6
  p_busy_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt > lat_t'(1) |=> !exec_done_o);
  // R9
  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R8
  p_err_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(valid_i && exec_done_o));
  // R5
  p_nop_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && exec_done_o && class_i == 4'd9 |=> !exec_done_o ##1 exec_done_o);
endmodule

bind exec_lat_seq exec_lat_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .class_i     (class_i),
  .exec_done_o (exec_done_o),
  .err_o       (err_o),
  .cnt         (cnt_q)
);

// File: tb/sim_exec_lat_seq.sv
`timescale 1ns/1ps
module sim_exec_lat_seq;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] class_i = 4'd0;
  logic       cond_i = 1'b0;
  logic       cond_met_i = 1'b0;
  logic       exec_done_o;
  logic       err_o;

  int checks = 0;
  int errors = 0;
  int run = 0;
  bit done_flag = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  exec_lat_seq u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .class_i     (class_i),
    .cond_i      (cond_i),
    .cond_met_i  (cond_met_i),
    .exec_done_o (exec_done_o),
    .err_o       (err_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: length of each low window vs scoreboard head
  always @(negedge clk) begin
    if (!rst_ni) run = 0;
    else if (!exec_done_o) run++;
    else if (run > 0) begin
      if (exp_q.size() == 0) chk("R6 spurious busy window", run, 0);
      else chk(tag_q.pop_front(), run, exp_q.pop_front());
      run = 0;
    end
  end

  task automatic wait_free();
    while (!exec_done_o) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [3:0] c, input logic cd, input logic mt,
                       input int exp, input string tag);
    wait_free();
    class_i = c; cond_i = cd; cond_met_i = mt; valid_i = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    valid_i = 1'b0;
    drain();
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 done in reset", int'(exec_done_o), 1);
    chk("R1 err in reset", int'(err_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", int'(exec_done_o), 1);
    chk("R1 err after reset", int'(err_o), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R7 idle
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R7 idle done", int'(exec_done_o), 1);
    end

    // R3 per-class latency
    issue(4'd0, 0, 0, 1, "R3 alu");
    issue(4'd1, 0, 0, 4, "R3 int muldiv");
    issue(4'd2, 0, 0, 4, "R3 flt muldiv");
    issue(4'd3, 0, 0, 2, "R3 mem");
    issue(4'd4, 0, 0, 1, "R3 imm");
    issue(4'd6, 0, 0, 4, "R3 callret");
    issue(4'd7, 0, 0, 4, "R3 trig");
    issue(4'd8, 0, 0, 1, "R3 move");

    // R4 branches
    issue(4'd5, 1, 0, 1, "R4 cond not met");
    issue(4'd5, 1, 1, 3, "R4 cond met");
    issue(4'd5, 0, 0, 3, "R4 uncond met0");
    issue(4'd5, 0, 1, 3, "R4 uncond met1");

    // R5
    issue(4'd9, 0, 0, 1, "R5 nop");
    issue(4'd10, 0, 0, 1, "R5 halt");

    // R2 + R6: accept, then present valid while busy
    wait_free();
    class_i = 4'd1; valid_i = 1'b1;
    exp_q.push_back(4); tag_q.push_back("R6 busy window length");
    @(negedge clk);
    chk("R2 done low after accept", int'(exec_done_o), 0);
    class_i = 4'd9;
    @(negedge clk);
    @(negedge clk);
    valid_i = 1'b0;
    drain();
    repeat (3) @(negedge clk);
    chk("R6 no extra acceptance", exp_q.size(), 0);

    // R10 back-to-back with valid held
    wait_free();
    class_i = 4'd3; valid_i = 1'b1;
    exp_q.push_back(2); tag_q.push_back("R10 first window");
    exp_q.push_back(2); tag_q.push_back("R10 second window");
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk("R10 one free cycle", int'(exec_done_o), 1);
    @(negedge clk);
    chk("R10 reaccepted next edge", int'(exec_done_o), 0);
    valid_i = 1'b0;
    drain();

    // R8 untimed classes
    wait_free();
    class_i = 4'd12; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk("R8 err on code 12", int'(err_o), 1);
    chk("R8 done stays high", int'(exec_done_o), 1);
    class_i = 4'd15; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk("R8 done high code 15", int'(exec_done_o), 1);
    repeat (2) @(negedge clk);
    chk("R8 no window from bad class", exp_q.size(), 0);

    // R9 sticky across legal work, cleared by reset
    issue(4'd3, 0, 0, 2, "R9 legal after error");
    chk("R9 err sticky", int'(err_o), 1);
    do_reset();
    issue(4'd0, 0, 0, 1, "R9 alu after reset");
    chk("R9 err stays clear", int'(err_o), 0);

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule